// File: doc/BRIEF.md
# Pipeline Interlock and Operand Forwarding Control

This block decides, for the instruction sitting in the Issue stage of a single-issue, in-order, five-stage pipeline, where each of its ALU operands must come from. The stages are Fetch, Issue, Execute, Buffer and Write. Each operand can come from the register file or from the result of an older instruction that has not yet retired. The block also decides whether that instruction must wait. ALU results are usable by the very next instruction with no delay. A load is different: its data only appears at the end of Buffer, so an instruction that needs it right behind the load is held back for exactly one cycle.

The block keeps a shadow of the producer tags for Execute, Buffer and Write. Each tag holds valid, write enable, load flag and destination specifier. The tags advance every clock. The Issue-stage decoder presents the source specifiers, their use flags and the instruction's own destination information. The block returns one forwarding code per operand and a stall request. While stall is high, the surrounding pipeline holds its Fetch and Issue registers. The bubble output tells the Execute stage that it receives an empty slot in that cycle.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An active-low reset (asynchronous) empties all three producer tags, so right after reset no operand is forwarded and no stall is raised.
- R2: A used source that matches the destination of a valid, writing, non-load instruction in Execute gets forwarding code 1 and causes no stall. This covers an address base computed by the instruction just ahead.
- R3: A used source whose youngest matching producer is in Buffer gets code 2. This holds for a load in Buffer as well, with no stall.
- R4: A used source whose youngest matching producer is in Write gets code 3. A used source with no matching producer gets code 0 (register file).
- R5: When several stages hold a matching producer, the youngest one wins, in the order Execute, Buffer, Write.
- R6: A valid Issue instruction with a used source matching a valid, writing load in Execute raises stall for exactly one cycle, provided its inputs are held. In the following cycle it gets code 2 for that source.
- R7: bubble equals stall, and after a stall cycle the Execute tag is empty (not valid, no write).
- R8: Specifier 15 never matches. A source of 15 always gets code 0 and never stalls, even against a load writing 15.
- R9: Producers with valid low or write enable low are ignored. An operand whose use flag is low gets code 0 and cannot stall.
- R10: When the Issue valid input is low, stall is low and both codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Issue stage holds a real instruction |
| iss_src_i | input | N_SRC x 4 | Source specifiers, operand 0 is A, operand 1 is B |
| iss_use_i | input | N_SRC | Per operand: the source is actually read |
| iss_dst_i | input | 4 | Destination specifier of the Issue instruction |
| iss_we_i | input | 1 | Issue instruction writes its destination |
| iss_load_i | input | 1 | Issue instruction is a load |
| fwd_sel_o | output | N_SRC x 2 | Per operand code: 0 register file, 1 Execute, 2 Buffer, 3 Write |
| stall_o | output | 1 | Hold Fetch and Issue this cycle |
| bubble_o | output | 1 | Execute receives an empty slot next |

## Verification
The assertions assume that the Issue inputs are known after reset. They also assume that a stalled instruction is presented again unchanged in the cycle after stall. The one-cycle stall and the empty Execute tag after a stall do not depend on this. The bench replays the subtract, dependent load, dependent add sequence and a longer instruction table. Each entry is driven once, just after a clock edge. During a stall the inputs are left untouched and the bench waits one clock before it reads the codes, so the stimulus never changes an instruction while it is held.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // register specifier width and number of tracked producer stages
    localparam int unsigned HZ_REG_W = 4;
    localparam int unsigned HZ_NSTG  = 3;   // 0 = Execute, 1 = Buffer, 2 = Write

    // stages whose load data is not ready yet for a consumer issuing now
    localparam logic [HZ_NSTG-1:0] HZ_LOAD_LATE = 3'b001;

    typedef struct packed {
        logic                valid;
        logic                we;
        logic                load;
        logic [HZ_REG_W-1:0] dst;
    } hz_tag_t;

    typedef enum logic [1:0] {
        FWD_RF = 2'd0,
        FWD_EX = 2'd1,
        FWD_BF = 2'd2,
        FWD_WR = 2'd3
    } hz_fwd_e;

endpackage

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe
    import hz_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stall_i,
    input  hz_tag_t               issue_tag_i,
    output hz_tag_t [HZ_NSTG-1:0] tags_o
);

    typedef struct packed {
        hz_tag_t [HZ_NSTG-1:0] stg;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = stall_i ? '0 : issue_tag_i;
        for (int k = 1; k < int'(HZ_NSTG); k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tags_o = st_q.stg;

    // a stalled cycle leaves Execute empty
    p_bubble_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> (!st_q.stg[0].valid && !st_q.stg[0].we));

    // Buffer always receives what Execute held one cycle earlier
    p_shift_buffer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.stg[1] == $past(st_q.stg[0])));

    // Write always receives what Buffer held one cycle earlier
    p_shift_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.stg[2] == $past(st_q.stg[1])));

endmodule

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
#(
    parameter int unsigned PC_ID = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  use_i,
    input  logic [HZ_REG_W-1:0]   src_i,
    input  hz_tag_t [HZ_NSTG-1:0] tags_i,
    output hz_fwd_e               sel_o,
    output logic                  late_o
);

    localparam logic [HZ_REG_W-1:0] PC_SPEC = HZ_REG_W'(PC_ID);

    logic [HZ_NSTG-1:0] hit;

    for (genvar k = 0; k < int'(HZ_NSTG); k++) begin : g_cmp
        assign hit[k] = use_i && (src_i != PC_SPEC) && tags_i[k].valid
                        && tags_i[k].we && (tags_i[k].dst == src_i);
    end

    // scan oldest to youngest so the youngest matching producer wins
    always_comb begin
        sel_o  = FWD_RF;
        late_o = 1'b0;
        for (int k = int'(HZ_NSTG) - 1; k >= 0; k--) begin
            if (hit[k]) begin
                sel_o  = hz_fwd_e'(2'(k + 1));
                late_o = tags_i[k].load && HZ_LOAD_LATE[k];
            end
        end
    end

    p_pc_never_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == PC_SPEC) |-> (sel_o == FWD_RF && !late_o));

    p_unused_rf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !use_i |-> (sel_o == FWD_RF && !late_o));

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int unsigned N_SRC = 2,
    parameter int unsigned PC_ID = 15
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             iss_valid_i,
    input  logic [N_SRC-1:0][HZ_REG_W-1:0]   iss_src_i,
    input  logic [N_SRC-1:0]                 iss_use_i,
    input  logic [HZ_REG_W-1:0]              iss_dst_i,
    input  logic                             iss_we_i,
    input  logic                             iss_load_i,
    output logic [N_SRC-1:0][1:0]            fwd_sel_o,
    output logic                             stall_o,
    output logic                             bubble_o
);

    hz_tag_t [HZ_NSTG-1:0] tags;
    hz_tag_t               issue_tag;
    logic    [N_SRC-1:0]   late;
    hz_fwd_e [N_SRC-1:0]   sel;

    always_comb begin
        issue_tag.valid = iss_valid_i;
        issue_tag.we    = iss_valid_i && iss_we_i;
        issue_tag.load  = iss_valid_i && iss_load_i;
        issue_tag.dst   = iss_dst_i;
    end

    for (genvar s = 0; s < int'(N_SRC); s++) begin : g_src
        hz_src_match #(
            .PC_ID (PC_ID)
        ) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .use_i  (iss_use_i[s]),
            .src_i  (iss_src_i[s]),
            .tags_i (tags),
            .sel_o  (sel[s]),
            .late_o (late[s])
        );
        assign fwd_sel_o[s] = iss_valid_i ? sel[s] : FWD_RF;
    end

    assign stall_o  = iss_valid_i && (|late);
    assign bubble_o = stall_o;

    hz_tag_pipe u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_i     (stall_o),
        .issue_tag_i (issue_tag),
        .tags_o      (tags)
    );

    // a load-use wait never lasts more than one cycle
    p_single_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    p_idle_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid_i |-> (!stall_o && fwd_sel_o == '0));

endmodule

// File: tb/pipe_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb_top;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            iss_valid = 1'b0;
    logic [1:0][3:0] iss_src = '0;
    logic [1:0]      iss_use = '0;
    logic [3:0]      iss_dst = '0;
    logic            iss_we = 1'b0;
    logic            iss_load = 1'b0;
    logic [1:0][1:0] fwd_sel;
    logic            stall;
    logic            bubble;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pipe_hazard_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .iss_valid_i (iss_valid),
        .iss_src_i   (iss_src),
        .iss_use_i   (iss_use),
        .iss_dst_i   (iss_dst),
        .iss_we_i    (iss_we),
        .iss_load_i  (iss_load),
        .fwd_sel_o   (fwd_sel),
        .stall_o     (stall),
        .bubble_o    (bubble)
    );

    typedef struct packed {
        logic       v;
        logic [3:0] a;
        logic [3:0] b;
        logic       ua;
        logic       ub;
        logic [3:0] d;
        logic       we;
        logic       ld;
        logic       xs;    // expect one stall cycle
        logic [1:0] sa;    // expected code operand A (after any stall)
        logic [1:0] sb;    // expected code operand B
        logic [3:0] req;   // requirement number exercised
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 4'd2,  4'd3,  1'b1, 1'b1, 4'd1,  1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd4},  // R4 subtract, no producer
        '{1'b1, 4'd1,  4'd0,  1'b1, 1'b0, 4'd2,  1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 4'd2},  // R2 load base from subtract
        '{1'b1, 4'd2,  4'd5,  1'b1, 1'b1, 4'd4,  1'b1, 1'b0, 1'b1, 2'd2, 2'd0, 4'd6},  // R6 add uses load
        '{1'b1, 4'd1,  4'd4,  1'b1, 1'b1, 4'd6,  1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 4'd2},  // R2 retired vs Execute
        '{1'b1, 4'd4,  4'd6,  1'b1, 1'b1, 4'd7,  1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 4'd3},  // R3 Buffer and Execute
        '{1'b1, 4'd4,  4'd15, 1'b1, 1'b1, 4'd15, 1'b1, 1'b0, 1'b0, 2'd3, 2'd0, 4'd4},  // R4 Write; writes PC
        '{1'b1, 4'd15, 4'd7,  1'b1, 1'b1, 4'd8,  1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 4'd8},  // R8 PC source ignored
        '{1'b1, 4'd8,  4'd7,  1'b1, 1'b1, 4'd3,  1'b1, 1'b0, 1'b0, 2'd0, 2'd3, 4'd9},  // R9 no-write producer
        '{1'b1, 4'd10, 4'd11, 1'b1, 1'b1, 4'd3,  1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd4},  // R4 none
        '{1'b1, 4'd3,  4'd3,  1'b1, 1'b0, 4'd12, 1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 4'd5},  // R5 youngest of two
        '{1'b1, 4'd12, 4'd12, 1'b1, 1'b1, 4'd9,  1'b1, 1'b0, 1'b1, 2'd2, 2'd2, 4'd6},  // R6 both operands on load
        '{1'b1, 4'd0,  4'd0,  1'b0, 1'b0, 4'd13, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd9},  // R9 unused operands
        '{1'b0, 4'd13, 4'd0,  1'b1, 1'b0, 4'd14, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd10}, // R10 empty issue slot
        '{1'b1, 4'd13, 4'd9,  1'b1, 1'b1, 4'd5,  1'b1, 1'b0, 1'b0, 2'd2, 2'd3, 4'd3},  // R3 load in Buffer, no stall
        '{1'b1, 4'd14, 4'd5,  1'b1, 1'b1, 4'd6,  1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 4'd9},  // R9 invalid producer
        '{1'b1, 4'd0,  4'd0,  1'b0, 1'b0, 4'd15, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd9},  // R9 load writing PC
        '{1'b1, 4'd15, 4'd15, 1'b1, 1'b1, 4'd1,  1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd8}   // R8 no stall on PC
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t t);
        iss_valid  = t.v;
        iss_src[0] = t.a;
        iss_src[1] = t.b;
        iss_use    = {t.ub, t.ua};
        iss_dst    = t.d;
        iss_we     = t.we;
        iss_load   = t.ld;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        iss_valid = 1'b1;
        iss_src = '0;
        iss_use = 2'b11;
        @(negedge clk);
        chk("R1", "stall after reset", int'(stall), 0);
        chk("R1", "code A after reset", int'(fwd_sel[0]), 0);
        @(posedge clk);
        #1 iss_valid = 1'b0;
        repeat (3) @(posedge clk);   // drain the tag pipe

        for (int i = 0; i < NV; i++) begin
            string rq;
            @(posedge clk);
            #1 drive(TBL[i]);
            rq = $sformatf("R%0d vec%0d", TBL[i].req, i);
            @(negedge clk);
            chk(rq, "stall", int'(stall), int'(TBL[i].xs));
            chk(rq, "bubble R7", int'(bubble), int'(TBL[i].xs));
            if (TBL[i].xs) begin
                @(posedge clk);
                @(negedge clk);
                chk(rq, "stall second cycle R6", int'(stall), 0);
            end
            chk(rq, "code A", int'(fwd_sel[0]), int'(TBL[i].sa));
            chk(rq, "code B", int'(fwd_sel[1]), int'(TBL[i].sb));
        end

        // R1: reset in flight clears a pending load
        @(posedge clk);
        #1 drive('{1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd1});
        @(posedge clk);
        #1 rst_n = 1'b0;
        iss_valid = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        drive('{1'b1, 4'd2, 4'd2, 1'b1, 1'b1, 4'd3, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd1});
        @(negedge clk);
        chk("R1", "stall after mid reset", int'(stall), 0);
        chk("R1", "code A after mid reset", int'(fwd_sel[0]), 0);

        // R7: bubble leaves Execute empty, seen as no Execute match next
        @(posedge clk);
        #1 drive('{1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 4'd6, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd7});
        @(posedge clk);
        #1 drive('{1'b1, 4'd6, 4'd0, 1'b1, 1'b0, 4'd6, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd7});
        @(negedge clk);
        chk("R7", "stall on load use", int'(stall), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R7", "code A from Buffer not Execute", int'(fwd_sel[0]), 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule